// File: doc/BRIEF.md
# Package Idle State Resolver

This block looks at the idle state reported by every core, together with a set of platform limit inputs, and works out how deep the whole package may sleep. It then drives the power actions for that depth: a minimum-frequency request, a retention-voltage request and a PLL shut-off. It also runs the way back out. Any wake event, or any change in the resolved depth, leads the package back to the active state. If the PLL was off, the block waits for the clock to relock before it reports that the exit is done.

How deep the package may go depends first on the shallowest core. Limit inputs for snoop latency, interrupt latency, non-snoop latency and sideband activity can then lower that depth further. Each limit input has its own programmable ceiling. The deepest package state that matches cores in C7 is never used, so all-C7 cores resolve to the same package state as all-C6 cores.

Cores must follow one rule on their inputs: a core that has left C0 returns to C0 before it reports another non-C0 state. The block reads all its inputs as plain level signals. No data moves through it, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pkgidle_resolver`

## Requirements
- R1: After reset, the package state is active (code 0), and the retention, PLL-off, minimum-frequency and exit-done outputs are all low.
- R2: Core state codes are C0=0, C1=1, C1E=2, C3=3, C6=4, C7=5. While the package is active, it stays active (package code 0) when any core reports C0 or when any wake bit is high at the clock edge.
- R3: The shallowest core state selects the natural package depth. Package codes are PC0=0, PC1=1, PC2=2, PC3=3, PC6=4. C1 or C1E selects PC1. C3 selects PC3. C6 or C7 selects PC6. PC2 is reached only when a limit lowers the depth.
- R4: The package code never exceeds 4, even when every core is in C7.
- R5: Each limit has an enable bit and a 3-bit ceiling. The resolved depth is the lowest of the natural depth and the ceilings of all enabled limits. A ceiling above 4 counts as 4. The ceiling of a disabled limit has no effect.
- R6: PC1 drives no power action. PC2 raises only the minimum-frequency output. PC3 and PC6 raise the minimum-frequency, retention-voltage and PLL-off outputs.
- R7: From the active state, with no wake bit high and a non-zero resolved depth, the package enters that depth at the next clock edge.
- R8: While idle, a high wake bit or a resolved depth that differs from the current one starts the exit at the next clock edge.
- R9: An exit from PC1 or PC2 gives one cycle in which the package code is 0, exit-done is high and minimum-frequency is high. The package is active after that cycle.
- R10: An exit from PC3 or PC6 first drops the PLL-off and retention outputs while keeping minimum-frequency high and the package code unchanged. It stays there until a relock acknowledge is seen at a clock edge. The exit-done cycle of R9 follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_state_i | input | NCORES*3 | Per-core idle state, core i at bits [3i+2:3i] |
| wake_i | input | NCORES | Per-core wake event |
| lim_en_i | input | NLIM | Enable of each platform limit (snoop, interrupt, non-snoop, sideband) |
| lim_cap_i | input | NLIM*3 | Ceiling of each limit, limit j at bits [3j+2:3j] |
| pll_lock_ack_i | input | 1 | PLL relock acknowledge |
| pkg_state_o | output | 3 | Current package state code |
| ret_volt_o | output | 1 | Retention voltage request |
| pll_off_o | output | 1 | PLL shut-off request |
| min_freq_o | output | 1 | Minimum-frequency operating point request |
| exit_done_o | output | 1 | One-cycle pulse when the exit to active completes |

## Verification
Uniform cores at each state code check the natural depth mapping on its own. Mixed sets such as C3 beside C6, C6 beside C7 and C1E beside C7 show that the shallowest core decides, not the average or the first core. Limits are applied one at a time, two at once with different ceilings, disabled with a ceiling of zero, and with an out-of-range ceiling; these patterns separate min-selection, enable gating and clipping. Exits are triggered by wake, by a core returning to C0 and by a change of limit alone. Relock acknowledge is held back for several cycles so that a done pulse issued too early would be seen. A long constrained-random run, with cores that follow the return-to-C0 rule, mixes all of these.

// File: rtl/pkgidle_pkg.sv
package pkgidle_pkg;
  localparam int CS_W = 3;
  localparam int PS_W = 3;

  localparam logic [CS_W-1:0] CS_C0  = 3'd0;
  localparam logic [CS_W-1:0] CS_C1  = 3'd1;
  localparam logic [CS_W-1:0] CS_C1E = 3'd2;
  localparam logic [CS_W-1:0] CS_C3  = 3'd3;
  localparam logic [CS_W-1:0] CS_C6  = 3'd4;

  localparam logic [PS_W-1:0] PD_PC0 = 3'd0;
  localparam logic [PS_W-1:0] PD_PC1 = 3'd1;
  localparam logic [PS_W-1:0] PD_PC2 = 3'd2;
  localparam logic [PS_W-1:0] PD_PC3 = 3'd3;
  localparam logic [PS_W-1:0] PD_PC6 = 3'd4;
  localparam logic [PS_W-1:0] PD_MAX = PD_PC6;

  typedef enum logic [1:0] {
    SQ_ACT    = 2'd0,
    SQ_IDLE   = 2'd1,
    SQ_RELOCK = 2'd2,
    SQ_DONE   = 2'd3
  } seq_t;
endpackage

// File: rtl/pkgidle_min_reduce.sv
module pkgidle_min_reduce #(
  parameter int N = 6,
  parameter int W = 3
) (
  input  logic [N*W-1:0] vals_i,
  output logic [W-1:0]   min_o
);
  logic [W-1:0] chain [N];

  assign chain[0] = vals_i[W-1:0];

  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      logic [W-1:0] cur;
      assign cur      = vals_i[i*W +: W];
      assign chain[i] = (cur < chain[i-1]) ? cur : chain[i-1];
    end
  endgenerate

  assign min_o = chain[N-1];
endmodule

// File: rtl/pkgidle_depth_cap.sv
module pkgidle_depth_cap
  import pkgidle_pkg::*;
#(
  parameter int NLIM = 4
) (
  input  logic [CS_W-1:0]      shallow_i,
  input  logic [NLIM-1:0]      lim_en_i,
  input  logic [NLIM*PS_W-1:0] lim_cap_i,
  output logic [PS_W-1:0]      depth_o
);
  logic [PS_W-1:0]      natural_depth;
  logic [NLIM*PS_W-1:0] eff_caps;
  logic [PS_W-1:0]      cap_min;

  always_comb begin
    if (shallow_i == CS_C0)
      natural_depth = PD_PC0;
    else if (shallow_i == CS_C1 || shallow_i == CS_C1E)
      natural_depth = PD_PC1;
    else if (shallow_i == CS_C3)
      natural_depth = PD_PC3;
    else
      natural_depth = PD_PC6;
  end

  generate
    for (genvar j = 0; j < NLIM; j++) begin : g_lim
      logic [PS_W-1:0] raw;
      assign raw = lim_cap_i[j*PS_W +: PS_W];
      assign eff_caps[j*PS_W +: PS_W] =
        !lim_en_i[j]   ? PD_MAX :
        (raw > PD_MAX) ? PD_MAX : raw;
    end
  endgenerate

  pkgidle_min_reduce #(.N(NLIM), .W(PS_W)) u_capmin (
    .vals_i (eff_caps),
    .min_o  (cap_min)
  );

  assign depth_o = (cap_min < natural_depth) ? cap_min : natural_depth;
endmodule

// File: rtl/pkgidle_seq.sv
module pkgidle_seq
  import pkgidle_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] target_i,
  input  logic            wake_any_i,
  input  logic            lock_ack_i,
  output logic [PS_W-1:0] pkg_state_o,
  output logic            ret_volt_o,
  output logic            pll_off_o,
  output logic            min_freq_o,
  output logic            exit_done_o
);
  seq_t            st, st_n;
  logic [PS_W-1:0] dep, dep_n;
  logic            deep;

  assign deep = (dep >= PD_PC3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_ACT;
      dep <= PD_PC0;
    end else begin
      st  <= st_n;
      dep <= dep_n;
    end
  end

  always_comb begin
    st_n  = st;
    dep_n = dep;
    case (st)
      SQ_ACT: begin
        if (target_i != PD_PC0 && !wake_any_i) begin
          st_n  = SQ_IDLE;
          dep_n = target_i;
        end
      end
      SQ_IDLE: begin
        if (wake_any_i || target_i != dep)
          st_n = deep ? SQ_RELOCK : SQ_DONE;
      end
      SQ_RELOCK: begin
        if (lock_ack_i)
          st_n = SQ_DONE;
      end
      default: begin
        st_n  = SQ_ACT;
        dep_n = PD_PC0;
      end
    endcase
  end

  always_comb begin
    pkg_state_o = PD_PC0;
    ret_volt_o  = 1'b0;
    pll_off_o   = 1'b0;
    min_freq_o  = 1'b0;
    exit_done_o = 1'b0;
    case (st)
      SQ_IDLE: begin
        pkg_state_o = dep;
        min_freq_o  = (dep >= PD_PC2);
        ret_volt_o  = deep;
        pll_off_o   = deep;
      end
      SQ_RELOCK: begin
        pkg_state_o = dep;
        min_freq_o  = 1'b1;
      end
      SQ_DONE: begin
        min_freq_o  = 1'b1;
        exit_done_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pkgidle_resolver.sv
module pkgidle_resolver
  import pkgidle_pkg::*;
#(
  parameter int NCORES = 6,
  parameter int NLIM   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORES*CS_W-1:0] core_state_i,
  input  logic [NCORES-1:0]      wake_i,
  input  logic [NLIM-1:0]        lim_en_i,
  input  logic [NLIM*PS_W-1:0]   lim_cap_i,
  input  logic                   pll_lock_ack_i,
  output logic [PS_W-1:0]        pkg_state_o,
  output logic                   ret_volt_o,
  output logic                   pll_off_o,
  output logic                   min_freq_o,
  output logic                   exit_done_o
);
  logic [CS_W-1:0] shallow;
  logic [PS_W-1:0] target;

  pkgidle_min_reduce #(.N(NCORES), .W(CS_W)) u_coremin (
    .vals_i (core_state_i),
    .min_o  (shallow)
  );

  pkgidle_depth_cap #(.NLIM(NLIM)) u_cap (
    .shallow_i (shallow),
    .lim_en_i  (lim_en_i),
    .lim_cap_i (lim_cap_i),
    .depth_o   (target)
  );

  pkgidle_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .target_i    (target),
    .wake_any_i  (|wake_i),
    .lock_ack_i  (pll_lock_ack_i),
    .pkg_state_o (pkg_state_o),
    .ret_volt_o  (ret_volt_o),
    .pll_off_o   (pll_off_o),
    .min_freq_o  (min_freq_o),
    .exit_done_o (exit_done_o)
  );
endmodule

// File: rtl/pkgidle_resolver_chk.sv
module pkgidle_resolver_chk #(
  parameter int NCORES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORES-1:0] wake_i,
  input logic             pll_lock_ack_i,
  input logic [2:0]       pkg_state_o,
  input logic             ret_volt_o,
  input logic             pll_off_o,
  input logic             min_freq_o,
  input logic             exit_done_o
);
  assert_pll_off_bundle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off_o |-> (ret_volt_o && min_freq_o));

  assert_never_pc7_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_state_o <= 3'd4);

  assert_no_done_at_pll_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_off_o) |-> !exit_done_o);

  assert_done_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_off_o && !exit_done_o && pkg_state_o >= 3'd3 && !pll_lock_ack_i) |=> !exit_done_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_done_o |=> !exit_done_o);

  assert_done_at_min_freq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_done_o |-> (min_freq_o && pkg_state_o == 3'd0));

  assert_wake_blocks_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state_o == 3'd0 && |wake_i) |=> pkg_state_o == 3'd0);
endmodule

bind pkgidle_resolver pkgidle_resolver_chk #(.NCORES(NCORES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wake_i         (wake_i),
  .pll_lock_ack_i (pll_lock_ack_i),
  .pkg_state_o    (pkg_state_o),
  .ret_volt_o     (ret_volt_o),
  .pll_off_o      (pll_off_o),
  .min_freq_o     (min_freq_o),
  .exit_done_o    (exit_done_o)
);

// File: tb/pkgidle_resolver_tb.sv
`timescale 1ns/1ps
module pkgidle_resolver_tb;
  localparam int NC = 6;
  localparam int NL = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC*3-1:0] core_state_i = '0;
  logic [NC-1:0]   wake_i = '0;
  logic [NL-1:0]   lim_en_i = '0;
  logic [NL*3-1:0] lim_cap_i = '0;
  logic            pll_lock_ack_i = 1'b0;
  logic [2:0]      pkg_state_o;
  logic            ret_volt_o, pll_off_o, min_freq_o, exit_done_o;

  int cs [NC];
  int lcap [NL];
  int n_chk = 0;
  int n_fail = 0;
  int m_st = 0;
  int m_dep = 0;

  always #2.5 clk = ~clk;

  pkgidle_resolver #(.NCORES(NC), .NLIM(NL)) u_dut (
    .clk (clk), .rst_n (rst_n), .core_state_i (core_state_i), .wake_i (wake_i),
    .lim_en_i (lim_en_i), .lim_cap_i (lim_cap_i), .pll_lock_ack_i (pll_lock_ack_i),
    .pkg_state_o (pkg_state_o), .ret_volt_o (ret_volt_o), .pll_off_o (pll_off_o),
    .min_freq_o (min_freq_o), .exit_done_o (exit_done_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int target_of();
    int mn = 7;
    int t;
    for (int i = 0; i < NC; i++) if (cs[i] < mn) mn = cs[i];
    if (mn == 0) t = 0;
    else if (mn <= 2) t = 1;
    else if (mn == 3) t = 3;
    else t = 4;
    for (int j = 0; j < NL; j++)
      if (lim_en_i[j]) begin
        int c = (lcap[j] > 4) ? 4 : lcap[j];
        if (c < t) t = c;
      end
    return t;
  endfunction

  task automatic apply();
    for (int i = 0; i < NC; i++) core_state_i[i*3 +: 3] = 3'(cs[i]);
    for (int j = 0; j < NL; j++) lim_cap_i[j*3 +: 3] = 3'(lcap[j]);
  endtask

  // one clock: update model at the edge, compare outputs 1 ns later
  task automatic step();
    int t;
    apply();
    @(posedge clk);
    t = target_of();
    case (m_st)
      0: if (t != 0 && wake_i == 0) begin m_st = 1; m_dep = t; end
      1: if (wake_i != 0 || t != m_dep) m_st = (m_dep >= 3) ? 2 : 3;
      2: if (pll_lock_ack_i) m_st = 3;
      default: begin m_st = 0; m_dep = 0; end
    endcase
    #1;
    chk("R3 state", int'(pkg_state_o), (m_st == 1 || m_st == 2) ? m_dep : 0);
    chk("R6 minfreq", int'(min_freq_o),
        (m_st == 2 || m_st == 3 || (m_st == 1 && m_dep >= 2)) ? 1 : 0);
    chk("R6 pll_off", int'(pll_off_o), (m_st == 1 && m_dep >= 3) ? 1 : 0);
    chk("R6 retention", int'(ret_volt_o), (m_st == 1 && m_dep >= 3) ? 1 : 0);
    chk("R9 done", int'(exit_done_o), (m_st == 3) ? 1 : 0);
    @(negedge clk);
  endtask

  // park all cores in C0, then set new per-core states (keeps the return-to-C0 rule)
  task automatic to_states(int a0, int a1, int a2, int a3, int a4, int a5);
    for (int i = 0; i < NC; i++) cs[i] = 0;
    wake_i = '0;
    pll_lock_ack_i = 1'b1;
    repeat (3) step();
    pll_lock_ack_i = 1'b0;
    cs[0] = a0; cs[1] = a1; cs[2] = a2; cs[3] = a3; cs[4] = a4; cs[5] = a5;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NC; i++) cs[i] = 0;
    for (int j = 0; j < NL; j++) lcap[j] = 0;
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 state", int'(pkg_state_o), 0);
    chk("R1 outs", int'({ret_volt_o, pll_off_o, min_freq_o, exit_done_o}), 0);
    @(negedge clk);

    // PC1 entry and shallow exit
    to_states(1, 1, 1, 1, 1, 1);
    step();
    chk("R7 enter PC1", int'(pkg_state_o), 1);
    chk("R6 PC1 no action", int'({ret_volt_o, pll_off_o, min_freq_o}), 0);
    cs[2] = 0;
    step();
    chk("R8 exit on C0", int'(pkg_state_o), 0);
    chk("R9 done pulse", int'(exit_done_o), 1);
    chk("R9 min freq", int'(min_freq_o), 1);
    step();
    chk("R9 back active", int'(exit_done_o), 0);
    chk("R2 C0 holds active", int'(pkg_state_o), 0);

    // PC3, wake, delayed relock
    to_states(3, 3, 3, 3, 3, 3);
    step();
    chk("R3 all C3", int'(pkg_state_o), 3);
    chk("R6 PC3 actions", int'({ret_volt_o, pll_off_o, min_freq_o}), 7);
    wake_i[0] = 1'b1;
    step();
    wake_i = '0;
    chk("R10 pll on", int'(pll_off_o), 0);
    chk("R10 ret off", int'(ret_volt_o), 0);
    chk("R10 state kept", int'(pkg_state_o), 3);
    repeat (3) step();
    chk("R10 wait ack", int'(exit_done_o), 0);
    pll_lock_ack_i = 1'b1;
    step();
    pll_lock_ack_i = 1'b0;
    chk("R10 done after ack", int'(exit_done_o), 1);
    step();
    step();
    chk("R7 reenter", int'(pkg_state_o), 3);

    // C7 everywhere, mixed sets
    to_states(5, 5, 5, 5, 5, 5);
    step();
    chk("R4 all C7", int'(pkg_state_o), 4);
    cs[4] = 0;
    step();
    chk("R8 exit deep", int'(pll_off_o), 0);
    to_states(3, 4, 5, 4, 5, 4);
    step();
    chk("R3 C3 with C6", int'(pkg_state_o), 3);
    to_states(4, 5, 5, 4, 4, 5);
    step();
    chk("R3 C6 with C7", int'(pkg_state_o), 4);
    to_states(5, 5, 5, 5, 5, 2);
    step();
    chk("R3 C1E shallowest", int'(pkg_state_o), 1);

    // limits
    lim_en_i = 4'b0001; lcap[0] = 2;
    to_states(5, 5, 5, 5, 5, 5);
    step();
    chk("R5 single cap", int'(pkg_state_o), 2);
    chk("R6 PC2 min freq only", int'({ret_volt_o, pll_off_o, min_freq_o}), 1);
    lim_en_i = 4'b0110; lcap[1] = 3; lcap[2] = 1;
    step();
    chk("R8 exit on depth change", int'(exit_done_o), 1);
    step();
    step();
    chk("R5 two caps lowest", int'(pkg_state_o), 1);
    lim_en_i = 4'b0000; lcap[0] = 0; lcap[1] = 0; lcap[2] = 0; lcap[3] = 0;
    to_states(5, 5, 5, 5, 5, 5);
    step();
    chk("R5 disabled ignored", int'(pkg_state_o), 4);
    lim_en_i = 4'b1000; lcap[3] = 7;
    to_states(5, 5, 5, 5, 5, 5);
    step();
    chk("R5 clip ceiling", int'(pkg_state_o), 4);
    lim_en_i = '0;

    // wake blocks entry
    to_states(3, 3, 3, 3, 3, 3);
    wake_i[5] = 1'b1;
    step();
    chk("R2 wake blocks entry", int'(pkg_state_o), 0);
    wake_i = '0;

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < NC; i++) begin
        if (cs[i] == 0) begin
          if ($urandom % 3 != 0) cs[i] = 1 + int'($urandom % 5);
        end else if ($urandom % 6 == 0) begin
          cs[i] = 0;
        end
      end
      wake_i = (($urandom % 12) == 0) ? NC'(1 << ($urandom % NC)) : '0;
      pll_lock_ack_i = ($urandom % 3) == 0;
      if ($urandom % 20 == 0) begin
        lim_en_i = NL'($urandom);
        for (int j = 0; j < NL; j++) lcap[j] = int'($urandom % 8);
      end
      step();
    end
    finish_run();
  end
endmodule